// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Periodic Interrupts

This block keeps wall-clock time for a chip: seconds, minutes, hours and a day count, advanced once per second by a prescaler that counts pulses of a reference-clock tick input. Software selects one of three reference rates through a control field and starts or stops the clock with an enable bit. It reads and writes the time and an alarm value through a small 16-bit register port that runs on the same bus clock as the rest of the logic.

When the running time reaches the alarm day, hour, minute and second, an alarm flag is raised. Other flags pulse at one second, at half-second steps, and at eight binary sub-multiples of the reference rate. Every flag has an enable bit. All enabled flags are combined into one level interrupt. Software clears a flag by writing a one to its bit.

Top module: `wallclock_rtc`

## Requirements
- R1: Register byte offsets are as follows:
  - 0x00: hour/minute, with hours in bits 12:8 and minutes in bits 5:0.
  - 0x04: seconds, in bits 5:0.
  - 0x08: alarm hour/minute, with the same layout as 0x00.
  - 0x0C: alarm seconds.
  - 0x10: control.
  - 0x14: status.
  - 0x18: enable.
  - 0x20: day.
  - 0x24: alarm day.

  Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`. Unlisted offsets read 0. Bits outside the fields read 0.
- R2: On each second tick, each of the following wraps to 0 and carries into the next field:
  - seconds, at 59 or above;
  - minutes, at 59 or above;
  - hours, at 23 or above.

  An hour wrap increments the day.
- R3: The day counter is `DAY_W` bits wide and wraps from 2^DAY_W-1 to 0. The full range is therefore 2^DAY_W*86400 seconds.
- R4: Control bits 6:5 pick the number of reference ticks per second, as follows:
  - 00 or 11: `DIV_A`.
  - 01: `DIV_B`.
  - 10: `DIV_C`.

  Only cycles with `ref_tick` high count toward the next second.
- R5: A write to the hour/minute, seconds or day register takes effect at the next clock edge. It also restarts the prescaler, so the next second tick comes after a full divisor of reference ticks.
- R6: Control bit 7 enables counting. Bits 7:5 read back as written. While bit 7 is 0, time and all periodic flags are frozen.
- R7: Status bit 2 (alarm) is set when the time changes to equal the alarm day, hour, minute and second. It stays set until cleared. It does not set again while the match persists. It is not set by reset.
- R8: Status bit 4 is set on every second tick. Status bit 7 is set at the half-period step and at the second tick.
- R9: Status bit 8+k (k = 0..7) is set once every 2^(SAMPLE_SHIFT+k) counted reference ticks.
- R10: Writing the status register clears each bit written as 1. A set in the same cycle wins over the clear. Bits written as 0 keep their value.
- R11: The enable register stores only the implemented bits, mask 0xFF95. Other bits read 0.
- R12: `irq` is registered. It is high one cycle after any bit of (status AND enable) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One pulse per reference-clock period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the following corner cases:
- **Carries.** It sets times just below the second-to-minute, minute-to-hour and hour-to-day boundaries, including the last day of the range. A design with a wrong wrap limit or a missing carry reads back an off-by-one field.
- **Prescaler restart.** It rewrites the time part-way through a second. A prescaler that is not restarted ticks early and shows one second too many.
- **Alarm edge detection.** It checks that clearing the alarm flag while the time still matches leaves it clear. A level-sensitive compare would set the flag again at once.
- **Stalls.** It holds the reference tick low, and also clears the enable bit. A design that counts bus clocks, or ignores the enable, moves the time and raises flags.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_HM   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_AHM  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ASEC = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IER  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DAY  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ADAY = 6'h24;

  localparam int BIT_ALM  = 2;
  localparam int BIT_1HZ  = 4;
  localparam int BIT_2HZ  = 7;
  localparam int BIT_SMP0 = 8;

  localparam logic [15:0] IRQ_MASK = 16'hFF95;

  typedef enum logic [1:0] {
    REF_A    = 2'b00,
    REF_B    = 2'b01,
    REF_C    = 2'b10,
    REF_RSVD = 2'b11
  } ref_sel_e;

  typedef struct packed {
    logic       sec;
    logic       half;
    logic [7:0] smp;
  } tick_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int DIV_A        = 32768,
  parameter int DIV_B        = 32000,
  parameter int DIV_C        = 38400,
  parameter int SAMPLE_SHIFT = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_en,
  input  logic       ref_tick,
  input  logic       restart,
  input  logic [1:0] ref_sel,
  output tick_t      ticks
);

  localparam int MAX_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAX_DIV = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
  localparam int CNT_W   = $clog2(MAX_DIV) + 1;
  localparam int SMP_W   = SAMPLE_SHIFT + 7;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_m1;
  logic [CNT_W-1:0] half_m1;
  logic [SMP_W-1:0] smp_q;
  logic [7:0]       smp_hit;
  logic             counted;
  logic             step;
  logic             sec_hit;

  // divisor chosen at run time; the reserved code falls back to the first rate
  always_comb begin
    unique case (ref_sel_e'(ref_sel))
      REF_B: begin
        div_m1  = CNT_W'(DIV_B - 1);
        half_m1 = CNT_W'(DIV_B / 2 - 1);
      end
      REF_C: begin
        div_m1  = CNT_W'(DIV_C - 1);
        half_m1 = CNT_W'(DIV_C / 2 - 1);
      end
      default: begin
        div_m1  = CNT_W'(DIV_A - 1);
        half_m1 = CNT_W'(DIV_A / 2 - 1);
      end
    endcase
  end

  assign counted = run_en & ref_tick;
  assign step    = counted & ~restart;
  assign sec_hit = step & (cnt_q >= div_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= sec_hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
    end else if (counted) begin
      smp_q <= smp_q + 1'b1;
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_smp
    localparam logic [SMP_W-1:0] MK = SMP_W'((64'd1 << (SAMPLE_SHIFT + k)) - 64'd1);
    assign smp_hit[k] = counted & ((smp_q & MK) == MK);
  end

  always_comb begin
    ticks.sec  = sec_hit;
    ticks.half = step & (cnt_q == half_m1);
    ticks.smp  = smp_hit;
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain #(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_hm,
  input  logic             wr_sec,
  input  logic             wr_day,
  input  logic [4:0]       hr_in,
  input  logic [5:0]       min_in,
  input  logic [5:0]       sec_in,
  input  logic [DAY_W-1:0] day_in,
  output logic [5:0]       sec_q,
  output logic [5:0]       min_q,
  output logic [4:0]       hr_q,
  output logic [DAY_W-1:0] day_q
);

  logic sec_wrap;
  logic min_wrap;
  logic hr_wrap;

  assign sec_wrap = sec_q >= 6'd59;
  assign min_wrap = min_q >= 6'd59;
  assign hr_wrap  = hr_q  >= 5'd23;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else begin
      if (wr_sec) sec_q <= sec_in;
      if (wr_hm) begin
        hr_q  <= hr_in;
        min_q <= min_in;
      end
      if (wr_day) day_q <= day_in;
      // the prescaler never ticks in a cycle that carries a time write
      if (tick) begin
        sec_q <= sec_wrap ? '0 : sec_q + 1'b1;
        if (sec_wrap) begin
          min_q <= min_wrap ? '0 : min_q + 1'b1;
          if (min_wrap) begin
            hr_q <= hr_wrap ? '0 : hr_q + 1'b1;
            if (hr_wrap) day_q <= day_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ahm,
  input  logic             wr_asec,
  input  logic             wr_aday,
  input  logic [4:0]       hr_in,
  input  logic [5:0]       min_in,
  input  logic [5:0]       sec_in,
  input  logic [DAY_W-1:0] day_in,
  input  logic [5:0]       cur_sec,
  input  logic [5:0]       cur_min,
  input  logic [4:0]       cur_hr,
  input  logic [DAY_W-1:0] cur_day,
  output logic [5:0]       alm_sec,
  output logic [5:0]       alm_min,
  output logic [4:0]       alm_hr,
  output logic [DAY_W-1:0] alm_day,
  output logic             hit
);

  logic match;
  logic match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_sec <= '0;
      alm_min <= '0;
      alm_hr  <= '0;
      alm_day <= '0;
    end else begin
      if (wr_asec) alm_sec <= sec_in;
      if (wr_ahm) begin
        alm_hr  <= hr_in;
        alm_min <= min_in;
      end
      if (wr_aday) alm_day <= day_in;
    end
  end

  assign match = (cur_day == alm_day) && (cur_hr == alm_hr) &&
                 (cur_min == alm_min) && (cur_sec == alm_sec);

  // reset marks the match as already seen so the all-zero state raises nothing
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b1;
    else     match_q <= match;
  end

  assign hit = match & ~match_q;

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] set_vec,
  input  logic        clr_wr,
  input  logic        ier_wr,
  input  logic [15:0] wdata,
  output logic [15:0] isr_q,
  output logic [15:0] ier_q,
  output logic        irq
);

  logic [15:0] clr_mask;

  assign clr_mask = clr_wr ? wdata : 16'h0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      ier_q <= '0;
      irq   <= 1'b0;
    end else begin
      isr_q <= ((isr_q & ~clr_mask) | set_vec) & IRQ_MASK;
      if (ier_wr) ier_q <= wdata & IRQ_MASK;
      irq <= |(isr_q & ier_q);
    end
  end

endmodule

// File: rtl/wallclock_rtc.sv
module wallclock_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_A        = 32768,
  parameter int DIV_B        = 32000,
  parameter int DIV_C        = 38400,
  parameter int DAY_W        = 16,
  parameter int SAMPLE_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);

  logic [2:0] ctrl_q;        // {enable, ref_sel[1:0]}
  logic       run_en;
  logic       wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday;
  logic       wr_ctrl, wr_isr, wr_ier;
  logic       time_wr;
  tick_t      ticks;
  logic       tick_sec;
  logic       alarm_hit;

  logic [5:0]       sec_val, min_val, a_sec, a_min;
  logic [4:0]       hr_val, a_hr;
  logic [DAY_W-1:0] day_val, a_day;
  logic [15:0]      set_vec;
  logic [15:0]      isr_q, ier_q;

  assign wr_hm   = bus_wr && (bus_addr == OFS_HM);
  assign wr_sec  = bus_wr && (bus_addr == OFS_SEC);
  assign wr_day  = bus_wr && (bus_addr == OFS_DAY);
  assign wr_ahm  = bus_wr && (bus_addr == OFS_AHM);
  assign wr_asec = bus_wr && (bus_addr == OFS_ASEC);
  assign wr_aday = bus_wr && (bus_addr == OFS_ADAY);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_isr  = bus_wr && (bus_addr == OFS_ISR);
  assign wr_ier  = bus_wr && (bus_addr == OFS_IER);
  assign time_wr = wr_hm | wr_sec | wr_day;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[7:5];
  end

  assign run_en = ctrl_q[2];

  rtc_prescaler #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SAMPLE_SHIFT(SAMPLE_SHIFT)
  ) u_presc (
    .clk(clk), .rst(rst), .run_en(run_en), .ref_tick(ref_tick),
    .restart(time_wr), .ref_sel(ctrl_q[1:0]), .ticks(ticks)
  );

  assign tick_sec = ticks.sec;

  rtc_time_chain #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst(rst), .tick(tick_sec),
    .wr_hm(wr_hm), .wr_sec(wr_sec), .wr_day(wr_day),
    .hr_in(bus_wdata[12:8]), .min_in(bus_wdata[5:0]),
    .sec_in(bus_wdata[5:0]), .day_in(bus_wdata[DAY_W-1:0]),
    .sec_q(sec_val), .min_q(min_val), .hr_q(hr_val), .day_q(day_val)
  );

  rtc_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
    .clk(clk), .rst(rst),
    .wr_ahm(wr_ahm), .wr_asec(wr_asec), .wr_aday(wr_aday),
    .hr_in(bus_wdata[12:8]), .min_in(bus_wdata[5:0]),
    .sec_in(bus_wdata[5:0]), .day_in(bus_wdata[DAY_W-1:0]),
    .cur_sec(sec_val), .cur_min(min_val), .cur_hr(hr_val), .cur_day(day_val),
    .alm_sec(a_sec), .alm_min(a_min), .alm_hr(a_hr), .alm_day(a_day),
    .hit(alarm_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_ALM]  = alarm_hit;
    set_vec[BIT_1HZ]  = ticks.sec;
    set_vec[BIT_2HZ]  = ticks.sec | ticks.half;
    set_vec[BIT_SMP0 +: 8] = ticks.smp;
  end

  rtc_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_wr(wr_isr), .ier_wr(wr_ier), .wdata(bus_wdata),
    .isr_q(isr_q), .ier_q(ier_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        OFS_HM:   bus_rdata <= {3'b000, hr_val, 2'b00, min_val};
        OFS_SEC:  bus_rdata <= {10'd0, sec_val};
        OFS_AHM:  bus_rdata <= {3'b000, a_hr, 2'b00, a_min};
        OFS_ASEC: bus_rdata <= {10'd0, a_sec};
        OFS_CTRL: bus_rdata <= {8'd0, ctrl_q, 5'd0};
        OFS_ISR:  bus_rdata <= isr_q;
        OFS_IER:  bus_rdata <= ier_q;
        OFS_DAY:  bus_rdata <= 16'(day_val);
        OFS_ADAY: bus_rdata <= 16'(a_day);
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic        clk,
  input logic        rst,
  input logic        tick_sec,
  input logic        time_wr,
  input logic        run_en,
  input logic [5:0]  sec_val,
  input logic [15:0] isr_q,
  input logic [15:0] ier_q,
  input logic        irq,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic [15:0] bus_wdata
);

  logic isr_wr;
  assign isr_wr = bus_wr && (bus_addr == 6'h14);

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_sec && sec_val == 6'd59) |=> (sec_val == 6'd0));

  assert_sec_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick_sec && !time_wr) |=> $stable(sec_val));

  assert_no_tick_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> !tick_sec);

  assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (isr_q[2] && !(isr_wr && bus_wdata[2])) |=> isr_q[2]);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (isr_wr && bus_wdata[4] && !tick_sec) |=> !isr_q[4]);

  assert_ier_mask_R11: assert property (@(posedge clk) disable iff (rst)
    (ier_q & 16'h006A) == 16'h0000);

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((isr_q & ier_q) != 16'h0000));

endmodule

bind wallclock_rtc rtc_checker u_chk (
  .clk(clk), .rst(rst), .tick_sec(tick_sec), .time_wr(time_wr),
  .run_en(run_en), .sec_val(sec_val), .isr_q(isr_q), .ier_q(ier_q),
  .irq(irq), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/wallclock_rtc_test.sv
module wallclock_rtc_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_DAY_W   = 9;
  localparam int unsigned RANGE = (32'd1 << TB_DAY_W) * 32'd86400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wallclock_rtc #(
    .DIV_A(8), .DIV_B(10), .DIV_C(12), .DAY_W(TB_DAY_W), .SAMPLE_SHIFT(1)
  ) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int unsigned div_for(input int unsigned sel);
    return (sel == 1) ? 10 : (sel == 2) ? 12 : 8;
  endfunction

  function automatic logic [15:0] hm_of(input int unsigned t);
    int unsigned tod = t % 86400;
    return 16'(((tod / 3600) << 8) | ((tod % 3600) / 60));
  endfunction

  function automatic int unsigned mk(input int unsigned d, h, m, s);
    return d * 86400 + h * 3600 + m * 60 + s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input int unsigned t);
    bus_write(6'h20, 16'(t / 86400));
    bus_write(6'h00, hm_of(t));
    bus_write(6'h04, 16'(t % 60));
  endtask

  task automatic check_time(input int unsigned t, input string req);
    logic [15:0] v;
    bus_read(6'h20, v); check(req, v, 16'(t / 86400));
    bus_read(6'h00, v); check(req, v, hm_of(t));
    bus_read(6'h04, v); check(req, v, 16'(t % 60));
  endtask

  // run k seconds on the chosen divisor, then read mid-period
  task automatic run_and_check(input int unsigned sel, input int unsigned t,
                               input int unsigned k, input string req);
    bus_write(6'h10, 16'(32'h80 | (sel << 5)));
    set_time(t);
    wait_cyc(div_for(sel) * k + 1);
    check_time((t + k) % RANGE, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);

    // reset state
    check("R12 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset rdata", bus_rdata, 16'h0000);
    bus_read(6'h10, v); check("R6 reset ctrl", v, 16'h0000);
    bus_read(6'h04, v); check("R2 reset seconds", v, 16'h0000);
    bus_read(6'h14, v); check("R7 no alarm at reset", v, 16'h0000);

    // enable register mask
    bus_write(6'h18, 16'hFFFF);
    bus_read(6'h18, v); check("R11 ier mask", v, 16'hFF95);
    bus_write(6'h18, 16'h0000);

    // control readback, frozen time while disabled
    bus_write(6'h10, 16'hFFFF);
    bus_read(6'h10, v); check("R6 ctrl readback", v, 16'h00E0);
    bus_write(6'h10, 16'h0060);
    set_time(mk(2, 13, 45, 7));
    wait_cyc(40);
    check_time(mk(2, 13, 45, 7), "R6 frozen when disabled");
    bus_read(6'h1C, v); check("R1 unmapped read", v, 16'h0000);
    bus_read(6'h00, v); check("R1 hour/minute packing", v, 16'h0D2D);

    // random starts, random divisor, a few seconds each
    for (int i = 0; i < 8; i++) begin
      int unsigned t, k, sel;
      t = mk($urandom % 512, $urandom % 24, $urandom % 60, $urandom % 60);
      k = $urandom % 4;
      sel = $urandom % 3;
      run_and_check(sel, t, k, "R4 random time advance");
    end

    // carry corners
    run_and_check(0, mk(5, 0, 59, 59), 1, "R2 minute to hour carry");
    run_and_check(1, mk(10, 23, 59, 59), 2, "R2 hour to day carry");
    run_and_check(2, mk(7, 4, 12, 59), 1, "R2 second to minute carry");
    run_and_check(0, RANGE - 1, 1, "R3 day counter wrap");
    run_and_check(3, mk(1, 1, 1, 1), 2, "R4 reserved select uses first divisor");

    // restart on time write
    bus_write(6'h10, 16'h0080);
    set_time(mk(3, 3, 3, 3));
    wait_cyc(4);
    set_time(mk(4, 4, 4, 4));
    wait_cyc(9);
    check_time(mk(4, 4, 4, 5), "R5 prescaler restart");

    // half-second and one-second flags after a restart
    set_time(mk(0, 0, 0, 0));
    bus_write(6'h14, 16'hFFFF);
    wait_cyc(3);
    bus_read(6'h14, v); check("R8 half tick before second", v & 16'h0090, 16'h0080);
    wait_cyc(3);
    bus_read(6'h14, v); check("R8 second tick flag", v & 16'h0010, 16'h0010);

    // sample flag
    bus_write(6'h14, 16'hFFFF);
    wait_cyc(4);
    bus_read(6'h14, v); check("R9 fastest sample flag", v & 16'h0100, 16'h0100);

    // no reference ticks: nothing moves
    ref_tick = 1'b0;
    set_time(mk(9, 9, 9, 9));
    bus_write(6'h14, 16'hFFFF);
    wait_cyc(30);
    bus_read(6'h14, v); check("R9 no flags without ref tick", v, 16'h0000);
    check_time(mk(9, 9, 9, 9), "R4 time held without ref tick");
    ref_tick = 1'b1;

    // alarm
    bus_write(6'h10, 16'h0080);
    bus_write(6'h18, 16'h0004);
    set_time(mk(0, 0, 0, 0));
    bus_write(6'h24, 16'd3);
    bus_write(6'h08, 16'h0C00);
    bus_write(6'h0C, 16'd12);
    set_time(mk(3, 12, 0, 10));
    bus_write(6'h14, 16'hFFFF);
    wait_cyc(14);
    check("R12 irq low before alarm", {31'd0, irq}, 32'd0);
    wait_cyc(3);
    check("R12 irq on alarm", {31'd0, irq}, 32'd1);
    bus_read(6'h14, v); check("R7 alarm flag set", v & 16'h0004, 16'h0004);
    bus_write(6'h14, 16'h0004);
    wait_cyc(2);
    check("R12 irq drops after clear", {31'd0, irq}, 32'd0);
    bus_read(6'h14, v); check("R7 no re-set while matching", v & 16'h0004, 16'h0000);
    check("R10 clear leaves other bits", v & 16'h0010, 16'h0010);
    bus_write(6'h14, 16'h0000);
    bus_read(6'h14, v); check("R10 zero write keeps bits", v & 16'h0010, 16'h0010);
    bus_write(6'h18, 16'h0000);
    wait_cyc(2);
    check("R12 irq masked by enable", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule